// File: doc/BRIEF.md
# Power-Down and Watchdog Status Controller

This block tracks whether a processor core is running or powered down, and it owns the watchdog that can bring the core back. It runs on an always-on clock. A separate single-cycle tick acts as the watchdog time base. That tick first passes through a postscaler that divides it by a selectable power of two, and the divided tick then advances an 8-bit watchdog count. Two status flags report the last event: a time-out flag and a power-down flag. A clock-run output gates the core oscillator.

The instruction decoder pulses a power-down strobe when the core executes its power-down instruction. On that strobe the watchdog count and the postscaler are cleared together. In the same step the time-out flag is set, the power-down flag is cleared, and the clock-run output drops. While the core sleeps, the watchdog keeps counting from the tick. The core wakes in one of two ways. A watchdog overflow wakes it and clears the time-out flag. An external wake request wakes it and leaves both flags as they were. If the watchdog overflows while the core is running, the block sends a one-cycle reset request and clears the time-out flag.

Top module: `pwrdn_wdt_ctrl`

## Requirements
- R1: After reset, `osc_run`=1, `tmo_flag`=1, `pdn_flag`=1, `wdt_value`=0 and `reset_pulse`=0.
- R2: The watchdog count advances by one only on every 2^`ps_sel`-th cycle in which `wdt_tick` is high. It never changes in a cycle where `wdt_tick` and `sleep_req` are both low.
- R3: A `sleep_req` taken while `osc_run`=1 has these effects in the next cycle: `wdt_value`=0, the postscaler is restarted from zero, `tmo_flag`=1, `pdn_flag`=0 and `osc_run`=0. The clear takes priority over a tick in the same cycle.
- R4: While `osc_run`=0, `pdn_flag` stays 0.
- R5: A `wake_req` while `osc_run`=0, with no watchdog overflow in that cycle, sets `osc_run`=1 in the next cycle and leaves `tmo_flag` and `pdn_flag` unchanged.
- R6: A `sleep_req` while asleep is ignored, and the count is not cleared. A `wake_req` while running is ignored.
- R7: A watchdog overflow while asleep sets `osc_run`=1 and `tmo_flag`=0 in the next cycle, and no `reset_pulse` is raised. This holds even when `wake_req` is high in the same cycle. The count has kept advancing during sleep.
- R8: A watchdog overflow while running drives `reset_pulse` high for exactly one cycle. It also clears `tmo_flag`, leaves `pdn_flag` and `osc_run` unchanged, and wraps `wdt_value` to 0.
- R9: If a `sleep_req` and an overflow fall in the same running cycle, the power-down wins. No `reset_pulse` is raised, and `tmo_flag`=1, `pdn_flag`=0, `wdt_value`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Decoded power-down instruction strobe |
| wake_req | input | 1 | External wake event |
| wdt_tick | input | 1 | Watchdog time-base enable, one cycle per tick |
| ps_sel | input | 3 | Postscaler exponent: divide by 2^ps_sel |
| osc_run | output | 1 | Core oscillator enable, low while asleep |
| tmo_flag | output | 1 | Time-out status flag |
| pdn_flag | output | 1 | Power-down status flag |
| wdt_value | output | 8 | Current watchdog count |
| reset_pulse | output | 1 | One-cycle reset request on overflow while running |

## Verification
The assertions assume that every input is synchronous to `clk` and that a wake cause is judged from `wake_req` one cycle before `osc_run` rises. They also assume that `ps_sel` is held constant while a divided period is in progress, because the limit comparison follows the live value. The stimulus changes all inputs on the falling edge and changes `ps_sel` only right after a reset or after a power-down clear, when the postscaler is at zero.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic {
    PM_AWAKE  = 1'b0,
    PM_ASLEEP = 1'b1
  } pm_state_e;
endpackage

// File: rtl/pdw_rst_sync.sv
module pdw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pdw_postscale.sv
module pdw_postscale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             adv
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] ps_q, ps_d, limit;

  // terminal value 2^sel - 1; wrap of the top bit gives all ones for the maximum sel
  assign limit = (CNT_W'(1) << sel) - CNT_W'(1);
  assign adv   = tick & (ps_q == limit);

  always_comb begin
    ps_d = ps_q;
    if (clr)       ps_d = '0;
    else if (tick) ps_d = (ps_q == limit) ? '0 : ps_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end
endmodule

// File: rtl/pdw_wdt_count.sv
module pdw_wdt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;

  assign ovf   = adv & (&cnt_q);
  assign count = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pdw_pm_ctrl.sv
module pdw_pm_ctrl
  import pdw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic ovf,
  output logic take_sleep,
  output logic osc_run,
  output logic tmo,
  output logic pdn,
  output logic rst_pulse
);
  pm_state_e st_q, st_d;
  logic      tmo_q, tmo_d, pdn_q, pdn_d, pulse_q, pulse_d;

  assign take_sleep = (st_q == PM_AWAKE) & sleep_req;

  always_comb begin
    st_d    = st_q;
    tmo_d   = tmo_q;
    pdn_d   = pdn_q;
    pulse_d = 1'b0;
    unique case (st_q)
      PM_AWAKE: begin
        if (sleep_req) begin
          st_d  = PM_ASLEEP;
          tmo_d = 1'b1;
          pdn_d = 1'b0;
        end else if (ovf) begin
          pulse_d = 1'b1;
          tmo_d   = 1'b0;
        end
      end
      PM_ASLEEP: begin
        if (ovf) begin
          st_d  = PM_AWAKE;
          tmo_d = 1'b0;
        end else if (wake_req) begin
          st_d = PM_AWAKE;
        end
      end
      default: st_d = PM_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PM_AWAKE;
      tmo_q   <= 1'b1;
      pdn_q   <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmo_q   <= tmo_d;
      pdn_q   <= pdn_d;
      pulse_q <= pulse_d;
    end
  end

  assign osc_run   = (st_q == PM_AWAKE);
  assign tmo       = tmo_q;
  assign pdn       = pdn_q;
  assign rst_pulse = pulse_q;
endmodule

// File: rtl/pwrdn_wdt_ctrl.sv
module pwrdn_wdt_ctrl #(
  parameter int WDT_W  = 8,
  parameter int SEL_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             wdt_tick,
  input  logic [SEL_W-1:0] ps_sel,
  output logic             osc_run,
  output logic             tmo_flag,
  output logic             pdn_flag,
  output logic [WDT_W-1:0] wdt_value,
  output logic             reset_pulse
);
  logic rst_sync_n;
  logic take_sleep;
  logic ps_adv;
  logic wdt_ovf;

  pdw_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_sync_n)
  );

  pdw_postscale #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_sync_n), .tick(wdt_tick), .clr(take_sleep),
    .sel(ps_sel), .adv(ps_adv)
  );

  pdw_wdt_count #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_sync_n), .adv(ps_adv), .clr(take_sleep),
    .count(wdt_value), .ovf(wdt_ovf)
  );

  pdw_pm_ctrl u_pm (
    .clk(clk), .rst_n(rst_sync_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .ovf(wdt_ovf), .take_sleep(take_sleep), .osc_run(osc_run),
    .tmo(tmo_flag), .pdn(pdn_flag), .rst_pulse(reset_pulse)
  );
endmodule

// File: rtl/pdw_chk.sv
module pdw_chk #(
  parameter int WDT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             wake_req,
  input logic             wdt_tick,
  input logic             osc_run,
  input logic             tmo_flag,
  input logic             pdn_flag,
  input logic [WDT_W-1:0] wdt_value,
  input logic             reset_pulse
);
  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_tick && !sleep_req) |=> $stable(wdt_value));

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_run && sleep_req) |=> (wdt_value == '0 && tmo_flag && !pdn_flag && !osc_run));

  // R4
  asleep_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> !pdn_flag);

  // R5
  ext_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && wake_req) |=> (osc_run && !pdn_flag));

  // R6
  awake_wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_run && wake_req && !sleep_req) |=> osc_run);

  // R7
  wdt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(osc_run) && !$past(wake_req)) |-> (!tmo_flag && !reset_pulse));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |=> !reset_pulse);

  // R8
  pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> (osc_run && !tmo_flag && wdt_value == '0));

  // R9
  sleep_over_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_run && sleep_req) |=> !reset_pulse);
endmodule

bind pwrdn_wdt_ctrl pdw_chk #(.WDT_W(WDT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sleep_req(sleep_req), .wake_req(wake_req),
  .wdt_tick(wdt_tick), .osc_run(osc_run), .tmo_flag(tmo_flag),
  .pdn_flag(pdn_flag), .wdt_value(wdt_value), .reset_pulse(reset_pulse)
);

// File: tb/sim_pwrdn_wdt_ctrl.sv
`timescale 1ns/1ps
module sim_pwrdn_wdt_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wake_req = 1'b0;
  logic       wdt_tick = 1'b0;
  logic [2:0] ps_sel = 3'd0;
  logic       osc_run, tmo_flag, pdn_flag, reset_pulse;
  logic [7:0] wdt_value;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwrdn_wdt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .wdt_tick(wdt_tick), .ps_sel(ps_sel), .osc_run(osc_run),
    .tmo_flag(tmo_flag), .pdn_flag(pdn_flag), .wdt_value(wdt_value),
    .reset_pulse(reset_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; wdt_tick = 1'b0; ps_sel = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one tick, then one idle cycle; returns at a falling edge
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      wdt_tick = 1'b1;
      @(negedge clk);
      wdt_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 osc_run", osc_run, 1);
    check("R1 tmo", tmo_flag, 1);
    check("R1 pdn", pdn_flag, 1);
    check("R1 wdt", wdt_value, 0);
    check("R1 pulse", reset_pulse, 0);
  endtask

  task automatic t_postscale();
    do_reset();
    ticks(5);
    check("R2 div1", wdt_value, 5);
    repeat (4) @(negedge clk);
    check("R2 hold no tick", wdt_value, 5);
    do_reset();
    ps_sel = 3'd2;
    ticks(3);
    check("R2 div4 early", wdt_value, 0);
    ticks(1);
    check("R2 div4", wdt_value, 1);
    do_reset();
    ps_sel = 3'd7;
    ticks(127);
    check("R2 div128 early", wdt_value, 0);
    ticks(1);
    check("R2 div128", wdt_value, 1);
  endtask

  task automatic t_sleep_entry();
    do_reset();
    ticks(5);
    ps_sel = 3'd2;
    ticks(2);
    sleep_req = 1'b1; wdt_tick = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0; wdt_tick = 1'b0;
    check("R3 wdt cleared", wdt_value, 0);
    check("R3 tmo", tmo_flag, 1);
    check("R3 pdn", pdn_flag, 0);
    check("R3 osc stop", osc_run, 0);
    ticks(3);
    check("R3 postscaler cleared", wdt_value, 0);
    ticks(1);
    check("R3 count while asleep", wdt_value, 1);
    check("R4 osc low", osc_run, 0);
    check("R4 pdn low", pdn_flag, 0);
  endtask

  task automatic t_sleep_ignored();
    do_reset();
    enter_sleep();
    ticks(3);
    enter_sleep();
    check("R6 no reclear", wdt_value, 3);
    check("R6 still asleep", osc_run, 0);
  endtask

  task automatic t_ext_wake();
    do_reset();
    enter_sleep();
    ticks(2);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    check("R5 osc back", osc_run, 1);
    check("R5 tmo kept", tmo_flag, 1);
    check("R5 pdn kept", pdn_flag, 0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    check("R6 awake wake osc", osc_run, 1);
    check("R6 awake wake wdt", wdt_value, 2);
    check("R6 awake wake pdn", pdn_flag, 0);
  endtask

  task automatic t_wdt_wake(input bit with_wake);
    do_reset();
    enter_sleep();
    ticks(255);
    check("R7 asleep before ovf", osc_run, 0);
    check("R7 count at max", wdt_value, 255);
    wdt_tick = 1'b1; wake_req = with_wake;
    @(negedge clk);
    wdt_tick = 1'b0; wake_req = 1'b0;
    check("R7 woken", osc_run, 1);
    check("R7 tmo cleared", tmo_flag, 0);
    check("R7 pdn", pdn_flag, 0);
    check("R7 no pulse", reset_pulse, 0);
  endtask

  task automatic t_awake_ovf();
    do_reset();
    ticks(255);
    wdt_tick = 1'b1;
    @(negedge clk);
    wdt_tick = 1'b0;
    check("R8 pulse", reset_pulse, 1);
    check("R8 tmo", tmo_flag, 0);
    check("R8 pdn", pdn_flag, 1);
    check("R8 osc", osc_run, 1);
    check("R8 wrap", wdt_value, 0);
    @(negedge clk);
    check("R8 pulse width", reset_pulse, 0);
  endtask

  task automatic t_sleep_vs_ovf();
    do_reset();
    ticks(255);
    wdt_tick = 1'b1; sleep_req = 1'b1;
    @(negedge clk);
    wdt_tick = 1'b0; sleep_req = 1'b0;
    check("R9 no pulse", reset_pulse, 0);
    check("R9 tmo", tmo_flag, 1);
    check("R9 pdn", pdn_flag, 0);
    check("R9 wdt", wdt_value, 0);
    check("R9 asleep", osc_run, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_postscale();
        t_sleep_entry();
        t_sleep_ignored();
        t_ext_wake();
        t_wdt_wake(1'b0);
        t_wdt_wake(1'b1);
        t_awake_ovf();
        t_sleep_vs_ovf();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule